// File: doc/BRIEF.md
# Deflection-Routing Switching Stage

This block is one 2x2 switching stage of a self-routing shuffle-exchange fabric that never buffers or drops a cell because of contention. Every input slot carries a cell header: a right-aligned routing tag, a count of the tag bits still to be used, the destination address, and the number of stages the cell has already crossed. The stage reads the highest remaining tag bit to pick an output, settles contention between the two inputs, consumes the bit, bumps the stage count and registers the result, so a cell appears one clock later.

When both cells want the same output, the loser is sent to the other output. Its tag is reloaded from its destination with the full length, so it begins routing again from the next stage. A cell that uses its last tag bit on the output it asked for is marked as arrived for the collection logic downstream. A cell whose stage budget is spent, or whose header has no usable tag bits, is discarded at the input and takes no part in contention. The shuffle wiring between stages and the collection of arrived cells sit outside this block.

Top module: `dfx_stage`

## Requirements
- R1: A synchronous reset clears both output valid bits on the next clock edge. Reset takes priority over any cell presented in the same cycle.
- R2: A cell at the inputs appears at an output exactly one clock later. A lone live cell goes to the output numbered by its routing bit. The routing bit is tag bit (len-1), where len is the remaining length: 0 selects output 0 and 1 selects output 1.
- R3: A cell that gets the output it asked for leaves with len reduced by one. Tag bits at positions len-1 and above are cleared. The destination is unchanged.
- R4: Every forwarded cell, routed or deflected, leaves with its stage count one higher.
- R5: When two live cells ask for the same output, the cell with the smaller remaining len wins it.
- R6: When two live cells ask for the same output with equal remaining len, the cell on input 0 wins.
- R7: The losing cell is put on the other output with its tag set to its destination and len set to ADDR_W (4 by default). Its arrived flag is 0.
- R8: Two live cells asking for different outputs are both routed as asked, and neither is deflected.
- R9: A cell with len 1 that wins its requested output leaves with arrived=1, len 0 and tag 0.
- R10: A cell whose stage count on entry is MAX_STAGES (10 by default) or more is discarded and does not contend. A cell entering with MAX_STAGES-1 is still forwarded.
- R11: A cell with len 0 or len greater than ADDR_W is discarded and does not contend.
- R12: An output that carries no cell shows valid, arrived, tag, len, destination and stage all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 2 | Cell present, one bit per input |
| inTag | input | 2 x ADDR_W | Remaining routing tag, right-aligned |
| inLen | input | 2 x LEN_W | Number of tag bits still to use |
| inDest | input | 2 x ADDR_W | Destination address |
| inStage | input | 2 x STAGE_W | Stages crossed so far |
| outValid | output | 2 | Cell present, one bit per output |
| outTag | output | 2 x ADDR_W | Updated routing tag |
| outLen | output | 2 x LEN_W | Updated remaining length |
| outDest | output | 2 x ADDR_W | Destination, passed through |
| outStage | output | 2 x STAGE_W | Incremented stage count |
| outArrived | output | 2 | Cell used its last bit on its requested output |

## Verification
The hardest situation to reach is a discarded cell that would otherwise have won contention. Here an expired or malformed cell sits on one input and shares a routing bit with a longer-tagged live cell on the other input, and the live cell must take its requested output rather than be deflected. The bench builds this case directly: it pairs a stage count at the budget limit with a shorter tag against a live cell that would lose if both were live. It also covers the last-bit case, where a deflection must suppress the arrived flag and reload the tag, and the boundary stage count just under the limit.

// File: rtl/dfx_pkg.sv
package dfx_pkg;

  // Strobes from the arbitration control to the header datapath.
  typedef struct packed {
    logic [1:0] keep;     // input k holds a live cell that is forwarded
    logic [1:0] deflect;  // input k lost contention
    logic [1:0] portSel;  // output index chosen for input k
  } ctrlStrobe_t;

endpackage

// File: rtl/dfx_ctrl.sv
module dfx_ctrl
  import dfx_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STAGE_W    = 4,
  parameter int MAX_STAGES = 10,
  localparam int LEN_W     = $clog2(ADDR_W + 1)
) (
  input  logic [1:0]                 inValid,
  input  logic [1:0][ADDR_W-1:0]     inTag,
  input  logic [1:0][LEN_W-1:0]      inLen,
  input  logic [1:0][STAGE_W-1:0]    inStage,
  output ctrlStrobe_t                strobe
);

  localparam logic [LEN_W-1:0]   LEN_MAX   = LEN_W'(ADDR_W);
  localparam logic [STAGE_W-1:0] STAGE_LIM = STAGE_W'(MAX_STAGES);

  logic [1:0] live;
  logic [1:0] reqBit;

  // Pick tag bit (len-1) without a variable shift.
  function automatic logic routeBit(input logic [ADDR_W-1:0] tag,
                                    input logic [LEN_W-1:0]  len);
    logic b;
    b = 1'b0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (len == LEN_W'(i + 1)) b = tag[i];
    end
    return b;
  endfunction

  for (genvar k = 0; k < 2; k++) begin : gInput
    always_comb begin
      live[k]   = inValid[k] && (inLen[k] != '0) && (inLen[k] <= LEN_MAX)
                  && (inStage[k] < STAGE_LIM);
      reqBit[k] = routeBit(inTag[k], inLen[k]);
    end
  end

  logic clash;
  logic loser;

  always_comb begin
    clash = live[0] && live[1] && (reqBit[0] == reqBit[1]);
    // Shorter remaining tag wins; on a tie input 0 wins, so input 1 loses.
    loser = (inLen[1] < inLen[0]) ? 1'b0 : 1'b1;

    strobe.keep    = live;
    strobe.deflect = 2'b00;
    strobe.portSel = reqBit;
    if (clash) begin
      strobe.deflect[loser] = 1'b1;
      strobe.portSel[loser] = ~reqBit[loser];
    end
  end

endmodule

// File: rtl/dfx_datapath.sv
module dfx_datapath
  import dfx_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STAGE_W    = 4,
  localparam int LEN_W     = $clog2(ADDR_W + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrlStrobe_t                strobe,
  input  logic [1:0][ADDR_W-1:0]     inTag,
  input  logic [1:0][LEN_W-1:0]      inLen,
  input  logic [1:0][ADDR_W-1:0]     inDest,
  input  logic [1:0][STAGE_W-1:0]    inStage,
  output logic [1:0]                 outValid,
  output logic [1:0][ADDR_W-1:0]     outTag,
  output logic [1:0][LEN_W-1:0]      outLen,
  output logic [1:0][ADDR_W-1:0]     outDest,
  output logic [1:0][STAGE_W-1:0]    outStage,
  output logic [1:0]                 outArrived
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(ADDR_W);

  // Rewritten header for each input, before steering.
  logic [1:0][ADDR_W-1:0]  nxtTag;
  logic [1:0][LEN_W-1:0]   nxtLen;
  logic [1:0][STAGE_W-1:0] nxtStage;
  logic [1:0]              nxtArr;

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      nxtStage[k] = inStage[k] + STAGE_W'(1);
      if (strobe.deflect[k]) begin
        nxtTag[k] = inDest[k];
        nxtLen[k] = LEN_MAX;
        nxtArr[k] = 1'b0;
      end else begin
        for (int i = 0; i < ADDR_W; i++) begin
          nxtTag[k][i] = inTag[k][i] && (LEN_W'(i + 1) < inLen[k]);
        end
        nxtLen[k] = inLen[k] - LEN_W'(1);
        nxtArr[k] = (inLen[k] == LEN_W'(1));
      end
    end
  end

  for (genvar j = 0; j < 2; j++) begin : gOutput
    logic                take0;
    logic                take1;
    logic                vReg;
    logic                aReg;
    logic [ADDR_W-1:0]   tReg;
    logic [LEN_W-1:0]    lReg;
    logic [ADDR_W-1:0]   dReg;
    logic [STAGE_W-1:0]  sReg;

    assign take0 = strobe.keep[0] && (strobe.portSel[0] == 1'(j));
    assign take1 = strobe.keep[1] && (strobe.portSel[1] == 1'(j));

    always_ff @(posedge clk) begin
      if (rst) begin
        vReg <= 1'b0; aReg <= 1'b0; tReg <= '0;
        lReg <= '0;   dReg <= '0;   sReg <= '0;
      end else if (take0) begin
        vReg <= 1'b1;        aReg <= nxtArr[0]; tReg <= nxtTag[0];
        lReg <= nxtLen[0];   dReg <= inDest[0]; sReg <= nxtStage[0];
      end else if (take1) begin
        vReg <= 1'b1;        aReg <= nxtArr[1]; tReg <= nxtTag[1];
        lReg <= nxtLen[1];   dReg <= inDest[1]; sReg <= nxtStage[1];
      end else begin
        vReg <= 1'b0; aReg <= 1'b0; tReg <= '0;
        lReg <= '0;   dReg <= '0;   sReg <= '0;
      end
    end

    assign outValid[j]   = vReg;
    assign outArrived[j] = aReg;
    assign outTag[j]     = tReg;
    assign outLen[j]     = lReg;
    assign outDest[j]    = dReg;
    assign outStage[j]   = sReg;
  end

endmodule

// File: rtl/dfx_stage.sv
module dfx_stage
  import dfx_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STAGE_W    = 4,
  parameter int MAX_STAGES = 10,
  localparam int LEN_W     = $clog2(ADDR_W + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 inValid,
  input  logic [1:0][ADDR_W-1:0]     inTag,
  input  logic [1:0][LEN_W-1:0]      inLen,
  input  logic [1:0][ADDR_W-1:0]     inDest,
  input  logic [1:0][STAGE_W-1:0]    inStage,
  output logic [1:0]                 outValid,
  output logic [1:0][ADDR_W-1:0]     outTag,
  output logic [1:0][LEN_W-1:0]      outLen,
  output logic [1:0][ADDR_W-1:0]     outDest,
  output logic [1:0][STAGE_W-1:0]    outStage,
  output logic [1:0]                 outArrived
);

  ctrlStrobe_t strobe;

  dfx_ctrl #(
    .ADDR_W(ADDR_W), .STAGE_W(STAGE_W), .MAX_STAGES(MAX_STAGES)
  ) uCtrl (
    .inValid(inValid), .inTag(inTag), .inLen(inLen), .inStage(inStage),
    .strobe(strobe)
  );

  dfx_datapath #(
    .ADDR_W(ADDR_W), .STAGE_W(STAGE_W)
  ) uPath (
    .clk(clk), .rst(rst), .strobe(strobe),
    .inTag(inTag), .inLen(inLen), .inDest(inDest), .inStage(inStage),
    .outValid(outValid), .outTag(outTag), .outLen(outLen),
    .outDest(outDest), .outStage(outStage), .outArrived(outArrived)
  );

endmodule

// File: rtl/dfx_stage_chk.sv
module dfx_stage_chk #(
  parameter int ADDR_W     = 4,
  parameter int STAGE_W    = 4,
  parameter int MAX_STAGES = 10,
  localparam int LEN_W     = $clog2(ADDR_W + 1)
) (
  input logic                       clk,
  input logic                       rst,
  input logic [1:0]                 inValid,
  input logic [1:0][ADDR_W-1:0]     inTag,
  input logic [1:0][LEN_W-1:0]      inLen,
  input logic [1:0][STAGE_W-1:0]    inStage,
  input logic [1:0]                 outValid,
  input logic [1:0][ADDR_W-1:0]     outTag,
  input logic [1:0][LEN_W-1:0]      outLen,
  input logic [1:0][ADDR_W-1:0]     outDest,
  input logic [1:0][STAGE_W-1:0]    outStage,
  input logic [1:0]                 outArrived
);

  logic       rstSeen;
  logic       prevRun;
  logic [1:0] liveIn;
  logic [1:0] wantHi;
  logic       loneReq;

  always_ff @(posedge clk) begin
    rstSeen <= rst;
    prevRun <= !rst;
  end

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      liveIn[k] = inValid[k] && inLen[k] >= LEN_W'(1) && int'(inLen[k]) <= ADDR_W
                  && int'(inStage[k]) < MAX_STAGES;
      wantHi[k] = 1'((inTag[k] >> (inLen[k] - LEN_W'(1))) & ADDR_W'(1));
    end
    loneReq = liveIn[0] ? wantHi[0] : wantHi[1];
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rstSeen |-> outValid == 2'b00);  // R1

  AST_LONE_ROUTE: assert property (@(posedge clk) disable iff (rst)
    prevRun && $past($countones(liveIn) == 1) |-> outValid == (2'b01 << $past(loneReq)));  // R2

  AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    prevRun && $past(liveIn == 2'b11) |->
      (outStage[0] == STAGE_W'($past(inStage[0]) + 1'b1) && outStage[1] == STAGE_W'($past(inStage[1]) + 1'b1)) ||
      (outStage[1] == STAGE_W'($past(inStage[0]) + 1'b1) && outStage[0] == STAGE_W'($past(inStage[1]) + 1'b1)));  // R4

  AST_RESTART_TAG0: assert property (@(posedge clk) disable iff (rst)
    outValid[0] && int'(outLen[0]) == ADDR_W |-> outTag[0] == outDest[0] && !outArrived[0]);  // R7

  AST_RESTART_TAG1: assert property (@(posedge clk) disable iff (rst)
    outValid[1] && int'(outLen[1]) == ADDR_W |-> outTag[1] == outDest[1] && !outArrived[1]);  // R7

  AST_ARRIVED_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (outArrived != 2'b00) |-> ((outArrived & ~outValid) == 2'b00) &&
      (!outArrived[0] || outLen[0] == '0) && (!outArrived[1] || outLen[1] == '0));  // R9

  AST_NO_LOSS: assert property (@(posedge clk) disable iff (rst)
    prevRun |-> $countones(outValid) == $countones($past(liveIn)));  // R10

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (outValid != 2'b11) |-> (outArrived & ~outValid) == 2'b00 &&
      (outValid[0] || (outTag[0] == '0 && outLen[0] == '0 && outStage[0] == '0)) &&
      (outValid[1] || (outTag[1] == '0 && outLen[1] == '0 && outStage[1] == '0)));  // R12

endmodule

bind dfx_stage dfx_stage_chk #(
  .ADDR_W(ADDR_W), .STAGE_W(STAGE_W), .MAX_STAGES(MAX_STAGES)
) uChk (.*);

// File: tb/dfx_stage_test.sv
`timescale 1ns/1ps
module dfx_stage_test;

  logic            clk = 1'b0;
  logic            rst;
  logic [1:0]      inValid;
  logic [1:0][3:0] inTag;
  logic [1:0][2:0] inLen;
  logic [1:0][3:0] inDest;
  logic [1:0][3:0] inStage;
  logic [1:0]      outValid;
  logic [1:0][3:0] outTag;
  logic [1:0][2:0] outLen;
  logic [1:0][3:0] outDest;
  logic [1:0][3:0] outStage;
  logic [1:0]      outArrived;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  dfx_stage uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inTag(inTag), .inLen(inLen),
    .inDest(inDest), .inStage(inStage), .outValid(outValid), .outTag(outTag),
    .outLen(outLen), .outDest(outDest), .outStage(outStage), .outArrived(outArrived)
  );

  task automatic clearIn();
    inValid = '0; inTag = '0; inLen = '0; inDest = '0; inStage = '0;
  endtask

  task automatic putCell(input int k, input logic [3:0] tag, input logic [2:0] len,
                         input logic [3:0] dest, input logic [3:0] stage);
    inValid[k] = 1'b1; inTag[k] = tag; inLen[k] = len;
    inDest[k] = dest;  inStage[k] = stage;
  endtask

  task automatic expectPort(input int j, input logic v, input logic [3:0] tag,
                            input logic [2:0] len, input logic [3:0] dest,
                            input logic [3:0] stage, input logic arr, input string req);
    checks++;
    if ({outValid[j], outTag[j], outLen[j], outDest[j], outStage[j], outArrived[j]} !==
        {v, tag, len, dest, stage, arr}) begin
      errors++;
      $display("FAIL %s out%0d: got v=%b tag=%b len=%0d dest=%b stage=%0d arr=%b, expected v=%b tag=%b len=%0d dest=%b stage=%0d arr=%b",
               req, j, outValid[j], outTag[j], outLen[j], outDest[j], outStage[j], outArrived[j],
               v, tag, len, dest, stage, arr);
    end
  endtask

  task automatic testReset();
    rst = 1'b1; clearIn();
    putCell(0, 4'b1010, 3'd4, 4'b1010, 4'd0);
    repeat (3) @(negedge clk);
    expectPort(0, 0, 0, 0, 0, 0, 0, "R1");
    expectPort(1, 0, 0, 0, 0, 0, 0, "R1");
    clearIn(); rst = 1'b0;
  endtask

  task automatic testLone();
    @(negedge clk); clearIn();
    putCell(0, 4'b1010, 3'd4, 4'b1010, 4'd0);
    @(negedge clk);
    expectPort(1, 1, 4'b0010, 3'd3, 4'b1010, 4'd1, 0, "R2 R3 R4");
    expectPort(0, 0, 0, 0, 0, 0, 0, "R12");
    clearIn(); putCell(1, 4'b0101, 3'd4, 4'b0101, 4'd2);
    @(negedge clk);
    expectPort(0, 1, 4'b0101, 3'd3, 4'b0101, 4'd3, 0, "R2 R3");
    expectPort(1, 0, 0, 0, 0, 0, 0, "R12");
    clearIn();
  endtask

  task automatic testBackToBack();
    @(negedge clk); clearIn();
    putCell(0, 4'b1000, 3'd4, 4'b1000, 4'd0);
    @(negedge clk);
    expectPort(1, 1, 4'b0000, 3'd3, 4'b1000, 4'd1, 0, "R2 first");
    clearIn(); putCell(1, 4'b0000, 3'd4, 4'b0000, 4'd0);
    @(negedge clk);
    expectPort(0, 1, 4'b0000, 3'd3, 4'b0000, 4'd1, 0, "R2 second");
    expectPort(1, 0, 0, 0, 0, 0, 0, "R2 drained");
    clearIn();
  endtask

  task automatic testSplit();
    @(negedge clk); clearIn();
    putCell(0, 4'b0110, 3'd3, 4'b1110, 4'd2);
    putCell(1, 4'b0001, 3'd2, 4'b1001, 4'd3);
    @(negedge clk);
    expectPort(1, 1, 4'b0010, 3'd2, 4'b1110, 4'd3, 0, "R8");
    expectPort(0, 1, 4'b0001, 3'd1, 4'b1001, 4'd4, 0, "R8");
    clearIn();
  endtask

  task automatic testShorterWins();
    @(negedge clk); clearIn();
    putCell(0, 4'b1000, 3'd4, 4'b1000, 4'd0);
    putCell(1, 4'b0011, 3'd2, 4'b0111, 4'd2);
    @(negedge clk);
    expectPort(1, 1, 4'b0001, 3'd1, 4'b0111, 4'd3, 0, "R5");
    expectPort(0, 1, 4'b1000, 3'd4, 4'b1000, 4'd1, 0, "R7");
    clearIn();
  endtask

  task automatic testTie();
    @(negedge clk); clearIn();
    putCell(0, 4'b0100, 3'd3, 4'b1100, 4'd1);
    putCell(1, 4'b0111, 3'd3, 4'b0111, 4'd4);
    @(negedge clk);
    expectPort(1, 1, 4'b0000, 3'd2, 4'b1100, 4'd2, 0, "R6");
    expectPort(0, 1, 4'b0111, 3'd4, 4'b0111, 4'd5, 0, "R6 R7");
    clearIn();
  endtask

  task automatic testArrive();
    @(negedge clk); clearIn();
    putCell(0, 4'b0001, 3'd1, 4'b0101, 4'd3);
    putCell(1, 4'b0000, 3'd1, 4'b0110, 4'd3);
    @(negedge clk);
    expectPort(1, 1, 4'b0000, 3'd0, 4'b0101, 4'd4, 1, "R9");
    expectPort(0, 1, 4'b0000, 3'd0, 4'b0110, 4'd4, 1, "R9");
    clearIn();
    putCell(0, 4'b0001, 3'd1, 4'b0011, 4'd5);
    putCell(1, 4'b0001, 3'd1, 4'b1011, 4'd6);
    @(negedge clk);
    expectPort(1, 1, 4'b0000, 3'd0, 4'b0011, 4'd6, 1, "R9 winner");
    expectPort(0, 1, 4'b1011, 3'd4, 4'b1011, 4'd7, 0, "R9 R7 deflected");
    clearIn();
  endtask

  task automatic testExpired();
    @(negedge clk); clearIn();
    putCell(0, 4'b0010, 3'd2, 4'b0010, 4'd10);
    putCell(1, 4'b0100, 3'd3, 4'b1100, 4'd5);
    @(negedge clk);
    expectPort(1, 1, 4'b0000, 3'd2, 4'b1100, 4'd6, 0, "R10 no contention");
    expectPort(0, 0, 0, 0, 0, 0, 0, "R10 dropped");
    clearIn();
    putCell(0, 4'b0000, 3'd2, 4'b0001, 4'd9);
    @(negedge clk);
    expectPort(0, 1, 4'b0000, 3'd1, 4'b0001, 4'd10, 0, "R10 last stage");
    clearIn();
  endtask

  task automatic testBadLen();
    @(negedge clk); clearIn();
    putCell(0, 4'b1111, 3'd0, 4'b1111, 4'd1);
    putCell(1, 4'b1111, 3'd5, 4'b1111, 4'd1);
    @(negedge clk);
    expectPort(0, 0, 0, 0, 0, 0, 0, "R11");
    expectPort(1, 0, 0, 0, 0, 0, 0, "R11");
    clearIn();
    putCell(0, 4'b0000, 3'd0, 4'b0000, 4'd1);
    putCell(1, 4'b0010, 3'd2, 4'b1010, 4'd1);
    @(negedge clk);
    expectPort(0, 0, 0, 0, 0, 0, 0, "R11 no contention");
    expectPort(1, 1, 4'b0000, 3'd1, 4'b1010, 4'd2, 0, "R11 survivor");
    clearIn();
  endtask

  task automatic testMidReset();
    @(negedge clk); clearIn();
    putCell(0, 4'b1000, 3'd4, 4'b1000, 4'd0);
    putCell(1, 4'b0000, 3'd4, 4'b0000, 4'd0);
    rst = 1'b1;
    @(negedge clk);
    expectPort(0, 0, 0, 0, 0, 0, 0, "R1 priority");
    expectPort(1, 0, 0, 0, 0, 0, 0, "R1 priority");
    rst = 1'b0; clearIn();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testLone();
    testBackToBack();
    testSplit();
    testShorterWins();
    testTie();
    testArrive();
    testExpired();
    testBadLen();
    testMidReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule